// File: doc/BRIEF.md
# Hierarchical Eight-Way Replacement Selector

This block holds the replacement state of one set in an eight-way set-associative cache and names the way to evict on a miss. The ways are grouped into four pairs, pair k holding ways 2k and 2k+1. Selection has two levels. A six-bit pairwise-order matrix ranks the four pairs by recency and yields the least recently used pair. One bit per pair then chooses between the even and the odd way of that pair.

The cache controller reports each hit with the way index. It raises a miss request when a line must be refilled. The victim output is always a function of the current state, so the controller reads it in the same cycle that it raises the miss. A miss counts as an access to the victim that is being refilled. A hit or a refill updates the pair order and the pair bit together at the next clock edge.

The access decoder has three named kinds. ACC_NONE applies when no strobe is present and changes nothing. ACC_HIT is taken whenever hit_vld is high, whether or not a miss is also raised. ACC_FILL is taken when only miss_req is high. There is no sequencing state. The kind is re-decoded every cycle, and each kind has a direct transition back to the decoder with no intermediate step.

Top module: `lru8_selector`

## Requirements
- R1: While rst_n is low and after it is released, with no access yet, victim_way reads 0. Every pair bit and matrix bit clears to 0, so pair 0 ranks oldest and its even way is chosen.
- R2: A hit on the even way 2k sets the bit of pair k to 1. When pair k is next the oldest pair, the victim is the odd way 2k+1.
- R3: A hit on the odd way 2k+1 sets the bit of pair k to 0. When pair k is next the oldest pair, the victim is the even way 2k.
- R4: The victim lies in the pair whose most recent access is the oldest of the four pairs. This is a true least-recently-used order over pairs, in which any access to either way of a pair refreshes that pair.
- R5: A miss with no hit refills the current victim and counts as an access to it. From reset, consecutive misses yield the ways 0, 2, 4, 6, 1, 3, 5, 7, 0.
- R6: When hit_vld and miss_req are high in the same cycle, only the hit updates the state and the miss is ignored.
- R7: In a cycle with neither hit_vld nor miss_req high, the state is unchanged and victim_way holds its value.
- R8: The pair bit is written directly rather than toggled, so repeated hits to the same way leave it at the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all state |
| hit_vld | input | 1 | A hit to hit_way occurred this cycle |
| hit_way | input | 3 | Way index of the hit, 0 to 7 |
| miss_req | input | 1 | A refill of victim_way takes place this cycle |
| victim_way | output | 3 | Way to replace, derived from the current state |

## Verification
The assertions assume that hit_way is a known value whenever hit_vld is high. They also assume that a miss always refills the way shown on victim_way in that cycle, which the block enforces because it takes the refill way from its own output. On that basis they check three things: any access moves the oldest pair away from the accessed pair, an idle cycle keeps the victim stable, and reset yields way 0. The stimulus drives only in-range way indices. It releases reset on a falling edge and applies every strobe for exactly one clock. It mixes hits, refills, collisions of hit and miss, and idle cycles, so the behaviour always stays inside what the properties assume.

// File: rtl/lru8_pkg.sv
package lru8_pkg;

    localparam int LRU_WAYS = 8;

    // Kind of access applied to the replacement state this cycle.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_kind_e;

    // Position of element (i,j), i<j, in the packed upper triangle of an n x n matrix.
    function automatic int tri_idx(input int i, input int j, input int n);
        return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
    endfunction

endpackage

// File: rtl/lru_pair_order.sv
module lru_pair_order
    import lru8_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    localparam int PAIR_W    = $clog2(NUM_PAIRS),
    localparam int MAT_BITS  = NUM_PAIRS * (NUM_PAIRS - 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [PAIR_W-1:0] upd_pair,
    output logic [PAIR_W-1:0] lru_pair
);

    // mat_q bit (i,j) set: pair i used more recently than pair j.
    logic [MAT_BITS-1:0]  mat_q;
    logic [MAT_BITS-1:0]  mat_d;
    logic [NUM_PAIRS-1:0] loses_all;

    always_comb begin
        mat_d = mat_q;
        if (upd_en) begin
            for (int i = 0; i < NUM_PAIRS; i++) begin
                for (int j = i + 1; j < NUM_PAIRS; j++) begin
                    if (upd_pair == PAIR_W'(i)) begin
                        mat_d[tri_idx(i, j, NUM_PAIRS)] = 1'b1;
                    end else if (upd_pair == PAIR_W'(j)) begin
                        mat_d[tri_idx(i, j, NUM_PAIRS)] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mat_q <= '0;
        end else begin
            mat_q <= mat_d;
        end
    end

    // A pair is oldest when every comparison names the other pair as newer.
    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_rank
            always_comb begin
                loses_all[p] = 1'b1;
                for (int q = 0; q < NUM_PAIRS; q++) begin
                    if (q > p) begin
                        if (mat_q[tri_idx(p, q, NUM_PAIRS)]) loses_all[p] = 1'b0;
                    end else if (q < p) begin
                        if (!mat_q[tri_idx(q, p, NUM_PAIRS)]) loses_all[p] = 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        lru_pair = '0;
        for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
            if (loses_all[p]) lru_pair = PAIR_W'(p);
        end
    end

endmodule

// File: rtl/lru_pair_bits.sv
module lru_pair_bits #(
    parameter  int NUM_PAIRS = 4,
    localparam int PAIR_W    = $clog2(NUM_PAIRS),
    localparam int WAY_W     = PAIR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic [PAIR_W-1:0] rd_pair,
    output logic              odd_lru
);

    // Bit set: odd way of the pair is the older one.
    logic [NUM_PAIRS-1:0] pbit_q;

    generate
        for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pbit_q[k] <= 1'b0;
                end else if (upd_en && (upd_way[WAY_W-1:1] == PAIR_W'(k))) begin
                    pbit_q[k] <= ~upd_way[0];
                end
            end
        end
    endgenerate

    assign odd_lru = pbit_q[rd_pair];

endmodule

// File: rtl/lru8_selector.sv
module lru8_selector
    import lru8_pkg::*;
#(
    parameter  int NUM_WAYS  = LRU_WAYS,
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int NUM_PAIRS = NUM_WAYS / 2,
    localparam int PAIR_W    = WAY_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_vld,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss_req,
    output logic [WAY_W-1:0] victim_way
);

    acc_kind_e         acc_kind;
    logic              upd_en;
    logic [WAY_W-1:0]  upd_way;
    logic [PAIR_W-1:0] lru_pair;
    logic              odd_lru;

    // Access decode: a hit outranks a simultaneous miss.
    always_comb begin
        unique case ({hit_vld, miss_req})
            2'b10, 2'b11: acc_kind = ACC_HIT;
            2'b01:        acc_kind = ACC_FILL;
            default:      acc_kind = ACC_NONE;
        endcase
    end

    always_comb begin
        unique case (acc_kind)
            ACC_HIT: begin
                upd_en  = 1'b1;
                upd_way = hit_way;
            end
            ACC_FILL: begin
                upd_en  = 1'b1;
                upd_way = victim_way;
            end
            default: begin
                upd_en  = 1'b0;
                upd_way = '0;
            end
        endcase
    end

    lru_pair_order #(.NUM_PAIRS(NUM_PAIRS)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_pair (upd_way[WAY_W-1:1]),
        .lru_pair (lru_pair)
    );

    lru_pair_bits #(.NUM_PAIRS(NUM_PAIRS)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .upd_way (upd_way),
        .rd_pair (lru_pair),
        .odd_lru (odd_lru)
    );

    assign victim_way = {lru_pair, odd_lru};

endmodule

// File: rtl/lru8_selector_chk.sv
module lru8_selector_chk #(
    parameter int WAY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_vld,
    input logic [WAY_W-1:0] hit_way,
    input logic             miss_req,
    input logic [WAY_W-1:0] victim_way
);

    // R1: reset leaves the even way of pair 0 as victim
    p_reset_victim_r1: assert property (@(posedge clk)
        !rst_n |=> victim_way == '0);

    // R4 and R6: a hit makes its pair the newest, so it cannot be the oldest next
    p_hit_pair_not_oldest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> victim_way[WAY_W-1:1] != $past(hit_way[WAY_W-1:1]));

    // R5: a refill moves the victim to another pair
    p_fill_moves_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !hit_vld) |=> victim_way[WAY_W-1:1] != $past(victim_way[WAY_W-1:1]));

    // R7: an idle cycle keeps the victim
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_vld && !miss_req) |=> $stable(victim_way));

    // R4: the victim is always a defined way
    p_victim_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(victim_way));

endmodule

bind lru8_selector lru8_selector_chk #(.WAY_W(WAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_vld    (hit_vld),
    .hit_way    (hit_way),
    .miss_req   (miss_req),
    .victim_way (victim_way)
);

// File: tb/tb_lru8_selector.sv
`timescale 1ns/1ps
module tb_lru8_selector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_vld = 1'b0;
    logic [2:0] hit_way = 3'd0;
    logic       miss_req = 1'b0;
    logic [2:0] victim_way;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference: pair timestamps plus last-used way parity per pair.
    int pair_ts [4];
    bit last_odd [4];
    int now_ts;

    always #2.5 clk = ~clk;

    lru8_selector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_vld    (hit_vld),
        .hit_way    (hit_way),
        .miss_req   (miss_req),
        .victim_way (victim_way)
    );

    // Stimulus vectors: {hit_vld, hit_way[2:0], miss_req}
    localparam logic [4:0] VEC [20] = '{
        5'b0_000_1, 5'b1_011_0, 5'b0_000_0, 5'b1_110_0,
        5'b0_000_1, 5'b1_101_1, 5'b1_001_0, 5'b0_000_1,
        5'b0_000_1, 5'b1_111_0, 5'b1_111_0, 5'b0_000_0,
        5'b1_100_0, 5'b0_000_1, 5'b1_010_1, 5'b1_000_0,
        5'b0_000_1, 5'b0_000_1, 5'b1_110_1, 5'b0_000_1
    };

    function automatic logic [2:0] model_victim();
        int best = 0;
        for (int p = 1; p < 4; p++) begin
            if (pair_ts[p] < pair_ts[best]) best = p;
        end
        return 3'(best * 2 + (last_odd[best] ? 0 : 1));
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 4; p++) begin
            pair_ts[p]  = p;
            last_odd[p] = 1'b1;
        end
        now_ts = 10;
    endtask

    task automatic model_touch(input logic [2:0] w);
        pair_ts[w[2:1]]  = now_ts;
        last_odd[w[2:1]] = w[0];
        now_ts++;
    endtask

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: victim_way actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic h, input logic [2:0] w, input logic m);
        string tag;
        logic [2:0] pre_victim;
        @(negedge clk);
        pre_victim = model_victim();
        hit_vld  = h;
        hit_way  = w;
        miss_req = m;
        @(posedge clk);
        #1;
        hit_vld  = 1'b0;
        miss_req = 1'b0;
        hit_way  = 3'd0;
        if (h) model_touch(w);
        else if (m) model_touch(pre_victim);
        if (h && m)      tag = "R6";
        else if (h)      tag = w[0] ? "R3" : "R2";
        else if (m)      tag = "R5";
        else             tag = "R7";
        check(tag, victim_way, model_victim());
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", victim_way, 3'd0);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R1", victim_way, 3'd0);
    endtask

    initial begin
        model_reset();
        do_reset();

        // Table walk with the reference order
        for (int k = 0; k < 20; k++) begin
            step(VEC[k][4], VEC[k][3:1], VEC[k][0]);
        end

        // R5: refill sequence from reset
        do_reset();
        begin
            logic [2:0] seq [9] = '{3'd0, 3'd2, 3'd4, 3'd6, 3'd1, 3'd3, 3'd5, 3'd7, 3'd0};
            for (int k = 0; k < 9; k++) begin
                #0;
                check("R5", victim_way, seq[k]);
                step(1'b0, 3'd0, 1'b1);
            end
        end

        // R4: pair order 3 oldest after hits on pairs 3,1,0,2
        do_reset();
        step(1'b1, 3'd7, 1'b0);
        step(1'b1, 3'd2, 1'b0);
        step(1'b1, 3'd1, 1'b0);
        step(1'b1, 3'd4, 1'b0);
        check("R4", victim_way, 3'd6);

        // R6: hit and miss together, miss ignored
        do_reset();
        step(1'b1, 3'd5, 1'b1);
        check("R6", victim_way, 3'd0);
        step(1'b1, 3'd0, 1'b1);
        check("R6", victim_way, 3'd2);

        // R8: repeated hits do not toggle the pair bit
        do_reset();
        repeat (3) step(1'b1, 3'd0, 1'b0);
        check("R8", victim_way, 3'd2);
        step(1'b1, 3'd2, 1'b0);
        step(1'b1, 3'd4, 1'b0);
        step(1'b1, 3'd6, 1'b0);
        check("R8", victim_way, 3'd1);

        // R7: idle cycles keep the victim
        repeat (3) step(1'b0, 3'd5, 1'b0);
        check("R7", victim_way, 3'd1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule